// File: doc/BRIEF.md
# DRAM Row-Extending Address Multiplexer

This block connects an 8-bit processor bus to a DRAM array with 512 rows and 512 columns. The array has nine shared address pins, so the block drives them in two phases. For an ordinary memory cycle it sends the upper nine bits of an 18-bit banked linear address as the row, with RAS. It then sends the lower nine bits as the column, with CAS. Write enable is asserted only while CAS is active, and only on writes.

The processor runs its own refresh cycles, but its refresh address is only seven bits wide. That reaches 128 rows, not 512. The block recognises each refresh cycle and performs a RAS-only refresh. It builds the full row from the processor's seven bits plus a two-bit extension counter that it keeps itself. The counter advances each time the processor's refresh value wraps around. Over four wraps of the processor counter, every row is reached.

With a 6 MHz processor issuing about one refresh per instruction, one full sweep of 512 refreshes takes well under 2 ms. The DRAM's limit is 8 ms. Refresh depends only on processor cycles, so it keeps working when no video fetches take place.

Top module: `dram_rowext_mux`

## Requirements
- R1: When reset is released, rasN, casN and weN are all high and the extension counter is zero. The first refresh after reset therefore uses row {2'b00, refresh value}.
- R2: A refresh cycle starts when mreqN falls while rfshN is low. Starting on the next clock, for RFSH_CYC cycles, rasN is low and dramAddr carries {extension counter, linAddr[6:0]} as sampled at the start of the refresh.
- R3: The extension counter advances by one, modulo 4, on a refresh whose 7-bit value is numerically below the previous refresh's value. An equal or higher value leaves the counter unchanged.
- R4: Throughout a refresh, casN and weN stay high.
- R5: A memory cycle starts when mreqN falls while rfshN is high. On the next clock rasN goes low and dramAddr is linAddr[17:9]. One clock later dramAddr becomes linAddr[8:0]. One clock after that, casN goes low and the column stays on the pins. The addresses are the ones sampled at the start of the cycle.
- R6: CAS stays low while mreqN stays low. On the clock after mreqN is seen high in the CAS phase, all strobes are high.
- R7: weN is low only during the CAS phase of a memory cycle that had wrN low when it started.
- R8: A refresh that starts during a memory cycle is held. The access completes its CAS phase and then ends. After one cycle with all strobes high, the held refresh runs with the row captured when it arrived.
- R9: 512 back-to-back refreshes whose 7-bit value steps by one refresh all 512 rows, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mreqN | input | 1 | Processor memory request, active low |
| rfshN | input | 1 | Processor refresh indication, active low |
| wrN | input | 1 | Write indication, active low, sampled at cycle start |
| linAddr | input | 18 | Banked linear address; bits 6:0 carry the refresh value |
| dramAddr | output | 9 | Multiplexed DRAM row/column address |
| rasN | output | 1 | Row address strobe, active low |
| casN | output | 1 | Column address strobe, active low |
| weN | output | 1 | DRAM write enable, active low |

## Verification
The properties assume that a new memory cycle begins only while the block is idle. The one exception is a single refresh, which may arrive during an access and is then held. They also assume the processor's refresh value moves forward in small steps, so that a decrease really means a wrap. The stimulus meets these assumptions. It starts each access or refresh only after the previous one has returned to idle, except in the directed held-refresh case. It advances the refresh value by one to three per refresh. Access addresses, write flags and CAS hold lengths are drawn at random. The linear address is changed after the row phase, to show that the latched addresses and not the live bus reach the pins.

// File: rtl/rowext_pkg.sv
package rowext_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_RFSH
  } state_e;

  typedef enum logic [1:0] {
    SEL_ROW,
    SEL_COL,
    SEL_RFSH
  } addrSel_e;

  // Strobes from the controller to the address datapath
  typedef struct packed {
    logic     latchAcc;   // capture row and column of an accepted access
    logic     latchRfsh;  // capture refresh value and step the extension
    addrSel_e addrSel;    // which latched address drives the pins
  } strobe_t;

endpackage

// File: rtl/rowext_ctrl.sv
module rowext_ctrl
  import rowext_pkg::*;
#(
  parameter int RFSH_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mreqN,
  input  logic    rfshN,
  input  logic    wrN,
  output strobe_t stb,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output logic    rfshActive
);

  localparam int CNT_W = (RFSH_CYC > 1) ? $clog2(RFSH_CYC) : 1;

  state_e           stateQ, stateD;
  logic             mreqHiQ;
  logic             pendQ, pendD;
  logic             wrQ;
  logic             goRfsh;
  logic             accEvt, rfshEvt;
  logic [CNT_W-1:0] cntQ;

  // A new bus cycle is a falling edge of the memory request
  assign accEvt  = !mreqN && mreqHiQ && rfshN;
  assign rfshEvt = !mreqN && mreqHiQ && !rfshN;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (pendQ || rfshEvt) stateD = ST_RFSH;
        else if (accEvt)      stateD = ST_ROW;
      end
      ST_ROW:  stateD = ST_COL;
      ST_COL:  stateD = ST_CAS;
      ST_CAS:  if (mreqN || pendQ) stateD = ST_IDLE;
      ST_RFSH: if (cntQ == '0) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign goRfsh = (stateD == ST_RFSH) && (stateQ != ST_RFSH);
  assign pendD  = goRfsh ? 1'b0 : (pendQ || rfshEvt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      mreqHiQ <= 1'b1;
      pendQ   <= 1'b0;
      wrQ     <= 1'b0;
      cntQ    <= '0;
    end else begin
      stateQ  <= stateD;
      mreqHiQ <= mreqN;
      pendQ   <= pendD;
      if (stb.latchAcc) wrQ <= !wrN;
      if (goRfsh) cntQ <= CNT_W'(RFSH_CYC - 1);
      else if (stateQ == ST_RFSH && cntQ != '0) cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    stb.latchAcc  = (stateQ == ST_IDLE) && !pendQ && accEvt;
    stb.latchRfsh = rfshEvt;
    unique case (stateQ)
      ST_COL, ST_CAS: stb.addrSel = SEL_COL;
      ST_RFSH:        stb.addrSel = SEL_RFSH;
      default:        stb.addrSel = SEL_ROW;
    endcase
  end

  assign rasN       = (stateQ == ST_IDLE);
  assign casN       = (stateQ != ST_CAS);
  assign weN        = !((stateQ == ST_CAS) && wrQ);
  assign rfshActive = (stateQ == ST_RFSH);

endmodule

// File: rtl/rowext_dpath.sv
module rowext_dpath
  import rowext_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int CPU_RF_W = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [2*ROW_W-1:0]        linAddr,
  output logic [ROW_W-1:0]          dramAddr,
  output logic [ROW_W-CPU_RF_W-1:0] extCnt
);

  localparam int EXT_W = ROW_W - CPU_RF_W;

  logic [ROW_W-1:0]    rowQ, colQ, rfRowQ;
  logic [EXT_W-1:0]    extQ, extNext;
  logic [CPU_RF_W-1:0] lastQ, curLow;
  logic                wrapHit;

  // The processor counter only moves forward, so a drop means it wrapped
  assign curLow  = linAddr[CPU_RF_W-1:0];
  assign wrapHit = curLow < lastQ;
  assign extNext = extQ + EXT_W'(wrapHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      rfRowQ <= '0;
      extQ   <= '0;
      lastQ  <= '0;
    end else begin
      if (stb.latchAcc) begin
        rowQ <= linAddr[2*ROW_W-1:ROW_W];
        colQ <= linAddr[ROW_W-1:0];
      end
      if (stb.latchRfsh) begin
        extQ   <= extNext;
        lastQ  <= curLow;
        rfRowQ <= {extNext, curLow};
      end
    end
  end

  always_comb begin
    unique case (stb.addrSel)
      SEL_COL:  dramAddr = colQ;
      SEL_RFSH: dramAddr = rfRowQ;
      default:  dramAddr = rowQ;
    endcase
  end

  assign extCnt = extQ;

endmodule

// File: rtl/dram_rowext_mux.sv
module dram_rowext_mux
  import rowext_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int CPU_RF_W = 7,
  parameter int RFSH_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mreqN,
  input  logic               rfshN,
  input  logic               wrN,
  input  logic [2*ROW_W-1:0] linAddr,
  output logic [ROW_W-1:0]   dramAddr,
  output logic               rasN,
  output logic               casN,
  output logic               weN
);

  strobe_t                   stb;
  logic [ROW_W-CPU_RF_W-1:0] extCnt;
  logic                      rfshActive;

  rowext_ctrl #(.RFSH_CYC(RFSH_CYC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mreqN      (mreqN),
    .rfshN      (rfshN),
    .wrN        (wrN),
    .stb        (stb),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .rfshActive (rfshActive)
  );

  rowext_dpath #(.ROW_W(ROW_W), .CPU_RF_W(CPU_RF_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .linAddr  (linAddr),
    .dramAddr (dramAddr),
    .extCnt   (extCnt)
  );

endmodule

// File: rtl/rowext_chk.sv
module rowext_chk #(
  parameter int ROW_W    = 9,
  parameter int CPU_RF_W = 7
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ROW_W-1:0]          dramAddr,
  input logic                      rasN,
  input logic                      casN,
  input logic                      weN,
  input logic [ROW_W-CPU_RF_W-1:0] extCnt,
  input logic                      rfshActive
);

  localparam int EXT_W = ROW_W - CPU_RF_W;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rasN && casN && weN && extCnt == '0)); // R1

  AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(extCnt) |-> (extCnt == $past(extCnt) + EXT_W'(1))); // R3

  AST_RFSH_RAS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rfshActive |-> (!rasN && casN && weN)); // R4

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN); // R5

  AST_CAS_AFTER_COL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> ($past(!rasN) && $stable(dramAddr))); // R5

  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !casN); // R7

endmodule

bind dram_rowext_mux rowext_chk #(.ROW_W(ROW_W), .CPU_RF_W(CPU_RF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dramAddr   (dramAddr),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .extCnt     (extCnt),
  .rfshActive (rfshActive)
);

// File: tb/sim_dram_rowext_mux.sv
module sim_dram_rowext_mux;

  localparam int RFSH_CYC = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mreqN = 1'b1;
  logic        rfshN = 1'b1;
  logic        wrN = 1'b1;
  logic [17:0] linAddr = '0;
  logic [8:0]  dramAddr;
  logic        rasN, casN, weN;

  int          errors = 0;
  int          checks = 0;
  logic [1:0]  extM = '0;
  logic [6:0]  lastM = '0;
  logic [6:0]  rCnt = '0;
  logic [511:0] seen = '0;
  bit          sweeping = 1'b0;

  always #4 clk = ~clk;

  dram_rowext_mux #(.RFSH_CYC(RFSH_CYC)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .mreqN    (mreqN),
    .rfshN    (rfshN),
    .wrN      (wrN),
    .linAddr  (linAddr),
    .dramAddr (dramAddr),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference for the row a refresh must hit (R2, R3)
  task automatic modelRow(input logic [6:0] v, output logic [8:0] row);
    if (v < lastM) extM = extM + 2'd1;
    lastM = v;
    row = {extM, v};
  endtask

  task automatic doRefresh(input logic [6:0] v);
    logic [8:0] er;
    @(negedge clk);
    mreqN = 1'b0; rfshN = 1'b0; linAddr = {11'($urandom), v};
    modelRow(v, er);
    for (int i = 0; i < RFSH_CYC; i++) begin
      @(negedge clk);
      chk("R2 refresh row", dramAddr, er);
      chk("R4 ras-only strobes", {rasN, casN, weN}, 3'b011);
      if (sweeping) seen[dramAddr] = 1'b1;
      mreqN = 1'b1; rfshN = 1'b1;
    end
    @(negedge clk);
    chk("R2 idle after refresh", {rasN, casN, weN}, 3'b111);
  endtask

  task automatic doAccess(input logic [17:0] a, input bit wr, input int hold);
    @(negedge clk);
    mreqN = 1'b0; rfshN = 1'b1; wrN = !wr; linAddr = a;
    @(negedge clk);
    chk("R5 row phase strobes", {rasN, casN, weN}, 3'b011);
    chk("R5 row address", dramAddr, a[17:9]);
    linAddr = 18'($urandom);
    @(negedge clk);
    chk("R5 column phase strobes", {rasN, casN, weN}, 3'b011);
    chk("R5 column address", dramAddr, a[8:0]);
    @(negedge clk);
    chk("R7 cas phase strobes", {rasN, casN, weN}, {2'b00, !wr});
    chk("R5 column held at cas", dramAddr, a[8:0]);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6 cas held", {rasN, casN, weN}, {2'b00, !wr});
    end
    mreqN = 1'b1; wrN = 1'b1;
    @(negedge clk);
    chk("R6 release after access", {rasN, casN, weN}, 3'b111);
  endtask

  task automatic doHeld(input logic [17:0] a, input logic [6:0] v);
    logic [8:0] er;
    @(negedge clk);
    mreqN = 1'b0; rfshN = 1'b1; wrN = 1'b1; linAddr = a;
    @(negedge clk);
    chk("R8 row phase", dramAddr, a[17:9]);
    mreqN = 1'b1;
    @(negedge clk);
    chk("R8 column phase", dramAddr, a[8:0]);
    mreqN = 1'b0; rfshN = 1'b0; linAddr = {11'($urandom), v};
    modelRow(v, er);
    @(negedge clk);
    chk("R8 access completes cas", {rasN, casN, weN}, 3'b001);
    chk("R8 column kept", dramAddr, a[8:0]);
    mreqN = 1'b1; rfshN = 1'b1;
    @(negedge clk);
    chk("R8 idle gap", {rasN, casN, weN}, 3'b111);
    for (int i = 0; i < RFSH_CYC; i++) begin
      @(negedge clk);
      chk("R8 held refresh strobes", {rasN, casN, weN}, 3'b011);
      chk("R8 held refresh row", dramAddr, er);
    end
    @(negedge clk);
    chk("R8 idle after held refresh", {rasN, casN, weN}, 3'b111);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {rasN, casN, weN}, 3'b111);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {rasN, casN, weN}, 3'b111);

    doRefresh(7'd5);       // R1 extension starts at zero
    doRefresh(7'd127);     // R3 increase, no step
    doRefresh(7'd0);       // R3 wrap steps extension to 1
    doRefresh(7'd0);       // R3 equal value, no step
    doAccess(18'h3FFFF, 1'b1, 0);
    doAccess(18'h00000, 1'b0, 2);
    doAccess(18'h2AA55, 1'b1, 1);
    doHeld(18'h15A3C, 7'd9);
    rCnt = 7'd9;

    for (int n = 0; n < 300; n++) begin
      int pick = $urandom_range(0, 4);
      if (pick < 2) begin
        rCnt = rCnt + 7'($urandom_range(1, 3));
        doRefresh(rCnt);
      end else if (pick < 4) begin
        doAccess(18'($urandom), 1'($urandom_range(0, 1)), $urandom_range(0, 2));
      end else begin
        rCnt = rCnt + 7'($urandom_range(1, 3));
        doHeld(18'($urandom), rCnt);
      end
    end

    sweeping = 1'b1;
    seen = '0;
    for (int n = 0; n < 512; n++) begin
      rCnt = rCnt + 7'd1;
      doRefresh(rCnt);
    end
    chk("R9 rows covered by sweep", $countones(seen), 512);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule